// File: doc/BRIEF.md
# XOR Tree Continuity Test Controller

This block gives a board-level manufacturing fixture a way to prove that every tested pin of a chip is soldered and connected. While the test mode is active, the values on a set of tested input pins feed a serial chain of two-input XOR stages, one pin per stage. The last stage drives an observable result, which also replaces the normal LED data. The fixture drives each pin high and then low and checks that the result toggles. While the mode is on, the block forces the output drivers of all tested pins to high impedance and turns off their pull resistors, so that the fixture can drive them without contention.

The mode is entered through a fixed walk of a TCK-clocked 16-state test access port state machine, which is qualified by a test-enable input. From Test-Logic-Reset the walk goes through Run-Test/Idle, Select-DR, Select-IR and Capture-IR into Shift-IR. There a 4-bit instruction is shifted in on TDI, LSB first, and the walk continues through Exit1-IR to Update-IR. The mode turns on only when the update sees the XOR-test opcode and the test-enable input is high. Three events end the mode immediately: the test-enable input going low, the asynchronous reset, or the port reaching Test-Logic-Reset. Ending the mode restores the functional output enables, pulls and LED data.

Top module: `xortree_test_ctrl`

## Requirements
- R1: While the mode is active, tree_o equals the XOR of all bits of pin_in_i. The path is purely combinational, so the value follows the pins without waiting for a clock.
- R2: While the mode is inactive, tree_o is 0.
- R3: While the mode is active, every bit of pin_oe_o is 0, which places the pins in high impedance. While the mode is inactive, pin_oe_o equals func_oe_i.
- R4: While the mode is active, every bit of pull_en_o is 0. While the mode is inactive, pull_en_o equals func_pull_en_i.
- R5: led_o equals tree_o while the mode is active and equals led_func_i otherwise.
- R6: From Test-Logic-Reset the entry walk is applied with TEST_EN and TDI high. The TMS values on successive TCK rising edges are 0,1,1,0,0. Four Shift-IR edges follow, which carry TDI = 0,1,0,1 (opcode 4'b1010, LSB first) with TMS = 0,0,0,1. Then come one edge with TMS=1, which enters Update-IR, and one more edge with TMS=0. test_mode_o is 1 after that final edge.
- R7: The same walk with any other opcode, for example 4'b0101, leaves test_mode_o at 0.
- R8: test_mode_o is never set while test_en_i is low. Driving test_en_i low clears test_mode_o at once without a TCK edge, and raising test_en_i again after a TCK edge does not restore the mode.
- R9: Five consecutive TCK rising edges with TMS high bring the port to Test-Logic-Reset and clear test_mode_o.
- R10: Asserting rst_ni low clears test_mode_o at once without a TCK edge and returns the port to Test-Logic-Reset.
- R11: While the mode is active, changing any single bit of pin_in_i inverts tree_o.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_en_i | input | 1 | Test-enable qualifier |
| tck_i | input | 1 | Test clock |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Test data in |
| pin_in_i | input | PIN_CNT | Input values of the tested pins |
| func_oe_i | input | PIN_CNT | Functional output enables of the tested pins |
| func_pull_en_i | input | PIN_CNT | Functional pull-resistor enables |
| led_func_i | input | 1 | Normal LED data |
| tree_o | output | 1 | Result of the XOR chain |
| test_mode_o | output | 1 | Test mode active |
| pin_oe_o | output | PIN_CNT | Output enables after the test override |
| pull_en_o | output | PIN_CNT | Pull enables after the test override |
| led_o | output | 1 | LED output, either the chain result or normal data |

## Verification
On every TCK edge the assertions check four things. The mode can only rise from Update-IR holding the XOR-test opcode with test enable high. A low test enable or a wrong opcode leaves the mode clear. Five TMS-high edges always reach Test-Logic-Reset. While the mode is active, the pads stay released and the result stays steady when the pins are steady. Only the bench scenarios can show that the tree result equals the parity of specific pin patterns and that a single-pin toggle inverts it. The same holds for the immediate, clock-free clearing on test-enable drop and on reset, and for the restoration of functional enables and LED data.

// File: rtl/xt_pkg.sv
package xt_pkg;
  typedef enum logic [3:0] {
    TAP_TLR, TAP_RTI,
    TAP_SEL_DR, TAP_CAP_DR, TAP_SHIFT_DR, TAP_EX1_DR, TAP_PAUSE_DR, TAP_EX2_DR, TAP_UPD_DR,
    TAP_SEL_IR, TAP_CAP_IR, TAP_SHIFT_IR, TAP_EX1_IR, TAP_PAUSE_IR, TAP_EX2_IR, TAP_UPD_IR
  } tap_state_e;

  localparam int unsigned TLR_TMS_CNT = 5;
endpackage

// File: rtl/xt_tap_fsm.sv
module xt_tap_fsm
  import xt_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TAP_TLR:      state_d = tms_i ? TAP_TLR    : TAP_RTI;
      TAP_RTI:      state_d = tms_i ? TAP_SEL_DR : TAP_RTI;
      TAP_SEL_DR:   state_d = tms_i ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR:   state_d = tms_i ? TAP_EX1_DR : TAP_SHIFT_DR;
      TAP_SHIFT_DR: state_d = tms_i ? TAP_EX1_DR : TAP_SHIFT_DR;
      TAP_EX1_DR:   state_d = tms_i ? TAP_UPD_DR : TAP_PAUSE_DR;
      TAP_PAUSE_DR: state_d = tms_i ? TAP_EX2_DR : TAP_PAUSE_DR;
      TAP_EX2_DR:   state_d = tms_i ? TAP_UPD_DR : TAP_SHIFT_DR;
      TAP_UPD_DR:   state_d = tms_i ? TAP_SEL_DR : TAP_RTI;
      TAP_SEL_IR:   state_d = tms_i ? TAP_TLR    : TAP_CAP_IR;
      TAP_CAP_IR:   state_d = tms_i ? TAP_EX1_IR : TAP_SHIFT_IR;
      TAP_SHIFT_IR: state_d = tms_i ? TAP_EX1_IR : TAP_SHIFT_IR;
      TAP_EX1_IR:   state_d = tms_i ? TAP_UPD_IR : TAP_PAUSE_IR;
      TAP_PAUSE_IR: state_d = tms_i ? TAP_EX2_IR : TAP_PAUSE_IR;
      TAP_EX2_IR:   state_d = tms_i ? TAP_UPD_IR : TAP_SHIFT_IR;
      TAP_UPD_IR:   state_d = tms_i ? TAP_SEL_DR : TAP_RTI;
      default:      state_d = TAP_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TAP_TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // checker: run length of TMS-high edges, saturating
  logic [2:0] tms_run_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                        tms_run_q <= '0;
    else if (!tms_i)                    tms_run_q <= '0;
    else if (tms_run_q < 3'(TLR_TMS_CNT)) tms_run_q <= tms_run_q + 3'd1;
  end

  assert_tlr_after_five_R9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (tms_run_q == 3'(TLR_TMS_CNT)) |-> (state_q == TAP_TLR));
endmodule

// File: rtl/xt_ir_ctrl.sv
module xt_ir_ctrl
  import xt_pkg::*;
#(
  parameter int unsigned IR_W   = 4,
  parameter logic [IR_W-1:0] OPCODE = 4'b1010
) (
  input  logic       tck_i,
  input  logic       rst_ni,
  input  tap_state_e state_i,
  input  logic       tdi_i,
  input  logic       test_en_i,
  output logic       mode_o
);
  localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);

  logic [IR_W-1:0] ir_q;
  logic            mode_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q <= '0;
    end else if (state_i == TAP_CAP_IR) begin
      ir_q <= IR_CAPTURE;
    end else if (state_i == TAP_SHIFT_IR) begin
      ir_q <= {tdi_i, ir_q[IR_W-1:1]};  // LSB enters first
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                                 mode_q <= 1'b0;
    else if (!test_en_i || state_i == TAP_TLR)   mode_q <= 1'b0;
    else if (state_i == TAP_UPD_IR)              mode_q <= (ir_q == OPCODE);
  end

  // exits act without waiting for an edge
  assign mode_o = mode_q & test_en_i & (state_i != TAP_TLR);

  assert_entry_opcode_R6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $rose(mode_q) |-> $past(state_i == TAP_UPD_IR && ir_q == OPCODE && test_en_i));

  assert_wrong_opcode_R7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == TAP_UPD_IR && ir_q != OPCODE) |=> !mode_q);

  assert_en_low_clears_R8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !test_en_i |=> !mode_q);
endmodule

// File: rtl/xt_xor_chain.sv
module xt_xor_chain #(
  parameter int unsigned PIN_CNT = 16
) (
  input  logic [PIN_CNT-1:0] pin_i,
  input  logic               en_i,
  output logic               tree_o
);
  logic [PIN_CNT-1:0] stage;

  assign stage[0] = pin_i[0];
  for (genvar g = 1; g < PIN_CNT; g++) begin : g_stage
    assign stage[g] = stage[g-1] ^ pin_i[g];
  end

  assign tree_o = en_i & stage[PIN_CNT-1];
endmodule

// File: rtl/xortree_test_ctrl.sv
module xortree_test_ctrl
  import xt_pkg::*;
#(
  parameter int unsigned PIN_CNT = 16,
  parameter int unsigned IR_W    = 4,
  parameter logic [IR_W-1:0] OPCODE = 4'b1010
) (
  input  logic               rst_ni,
  input  logic               test_en_i,
  input  logic               tck_i,
  input  logic               tms_i,
  input  logic               tdi_i,
  input  logic [PIN_CNT-1:0] pin_in_i,
  input  logic [PIN_CNT-1:0] func_oe_i,
  input  logic [PIN_CNT-1:0] func_pull_en_i,
  input  logic               led_func_i,
  output logic               tree_o,
  output logic               test_mode_o,
  output logic [PIN_CNT-1:0] pin_oe_o,
  output logic [PIN_CNT-1:0] pull_en_o,
  output logic               led_o
);
  tap_state_e tap_state;
  logic       mode;
  logic       tree;

  xt_tap_fsm u_tap (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (tap_state)
  );

  xt_ir_ctrl #(.IR_W(IR_W), .OPCODE(OPCODE)) u_ir (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .state_i   (tap_state),
    .tdi_i     (tdi_i),
    .test_en_i (test_en_i),
    .mode_o    (mode)
  );

  xt_xor_chain #(.PIN_CNT(PIN_CNT)) u_chain (
    .pin_i  (pin_in_i),
    .en_i   (mode),
    .tree_o (tree)
  );

  assign tree_o      = tree;
  assign test_mode_o = mode;
  assign pin_oe_o    = func_oe_i & ~{PIN_CNT{mode}};
  assign pull_en_o   = func_pull_en_i & ~{PIN_CNT{mode}};
  assign led_o       = mode ? tree : led_func_i;

  assert_pads_released_R3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    test_mode_o |-> (pin_oe_o == '0 && pull_en_o == '0));

  assert_idle_tree_low_R2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !test_mode_o |-> (tree_o == 1'b0 && led_o == led_func_i));

  assert_tree_steady_R1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    ($stable(pin_in_i) && $stable(test_mode_o) && test_mode_o) |-> $stable(tree_o));
endmodule

// File: tb/xortree_test_ctrl_bench.sv
module xortree_test_ctrl_bench;
  localparam int N = 8;

  logic rst_ni, test_en_i, tck_i, tms_i, tdi_i, led_func_i;
  logic [N-1:0] pin_in_i, func_oe_i, func_pull_en_i;
  logic tree_o, test_mode_o, led_o;
  logic [N-1:0] pin_oe_o, pull_en_o;

  int checks = 0, failures = 0;

  xortree_test_ctrl #(.PIN_CNT(N)) u_xortree_test_ctrl (
    .rst_ni(rst_ni), .test_en_i(test_en_i), .tck_i(tck_i), .tms_i(tms_i), .tdi_i(tdi_i),
    .pin_in_i(pin_in_i), .func_oe_i(func_oe_i), .func_pull_en_i(func_pull_en_i),
    .led_func_i(led_func_i), .tree_o(tree_o), .test_mode_o(test_mode_o),
    .pin_oe_o(pin_oe_o), .pull_en_o(pull_en_o), .led_o(led_o)
  );

  initial tck_i = 1'b0;
  always #10 tck_i = ~tck_i;  // 50 MHz

  // pattern, expected parity
  localparam int NV = 6;
  localparam logic [N-1:0] PAT_TBL [NV] = '{8'h00, 8'hFF, 8'h01, 8'hA5, 8'h7F, 8'h3C};
  localparam logic         PAR_TBL [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic tms, input logic tdi);
    @(negedge tck_i);
    tms_i = tms;
    tdi_i = tdi;
    @(posedge tck_i);
    #1;
  endtask

  task automatic to_tlr();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
  endtask

  task automatic enter(input logic [3:0] op);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(i == 3, op[i]);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; test_en_i = 1'b1; tms_i = 1'b0; tdi_i = 1'b1;
    pin_in_i = '0; func_oe_i = 8'hC3; func_pull_en_i = 8'h5A; led_func_i = 1'b1;
    #35 rst_ni = 1'b1;
    #1;
    // reset state
    chk("R10 reset mode", test_mode_o, 0);
    chk("R2 reset tree", tree_o, 0);
    chk("R3 reset oe", pin_oe_o, 8'hC3);
    chk("R4 reset pull", pull_en_o, 8'h5A);
    chk("R5 reset led", led_o, 1);

    enter(4'b1010);
    chk("R6 entry sets mode", test_mode_o, 1);
    chk("R3 oe released", pin_oe_o, 0);
    chk("R4 pulls off", pull_en_o, 0);

    for (int v = 0; v < NV; v++) begin
      pin_in_i = PAT_TBL[v];
      #1;
      chk("R1 parity", tree_o, PAR_TBL[v]);
      chk("R5 led carries tree", led_o, PAR_TBL[v]);
    end

    pin_in_i = '0;
    for (int p = 0; p < N; p++) begin
      pin_in_i[p] = 1'b1; #1;
      chk("R11 pin high toggles", tree_o, 1);
      pin_in_i[p] = 1'b0; #1;
      chk("R11 pin low toggles", tree_o, 0);
    end

    // TEST_EN drop, no clock edge
    pin_in_i = 8'h01;
    @(negedge tck_i);
    test_en_i = 1'b0; #1;
    chk("R8 en drop clears", test_mode_o, 0);
    chk("R2 idle tree", tree_o, 0);
    chk("R3 oe restored", pin_oe_o, 8'hC3);
    chk("R5 led restored", led_o, 1);
    @(posedge tck_i); #1;
    test_en_i = 1'b1; #1;
    chk("R8 no restore", test_mode_o, 0);

    to_tlr();
    enter(4'b0101);
    chk("R7 wrong opcode", test_mode_o, 0);

    to_tlr();
    test_en_i = 1'b0;
    enter(4'b1010);
    chk("R8 gated entry", test_mode_o, 0);
    test_en_i = 1'b1; #1;
    chk("R8 gated entry late en", test_mode_o, 0);

    to_tlr();
    enter(4'b1010);
    chk("R6 re-entry", test_mode_o, 1);
    to_tlr();
    chk("R9 tlr clears", test_mode_o, 0);
    chk("R4 pull restored", pull_en_o, 8'h5A);

    enter(4'b1010);
    chk("R6 entry before reset", test_mode_o, 1);
    @(negedge tck_i);
    rst_ni = 1'b0; #1;
    chk("R10 async reset clears", test_mode_o, 0);
    #5 rst_ni = 1'b1;
    enter(4'b1010);
    chk("R10 tap back in tlr", test_mode_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule